// File: doc/BRIEF.md
# Up/Down Interval Timer

This block is a 32-bit timer peripheral sitting on a plain word-oriented register bus with single-cycle reads and writes and no wait states. Software picks a count direction and a power-of-two clock divider in a control register, optionally preloads the counter, and then starts or stops counting with pulse-style command writes. Every time the counter wraps it raises an overflow flag (counting up) or an underflow flag (counting down). It keeps running after the wrap.

The flags stay set until software clears them. Software can change them in two ways: through a write-one-to-set alias and through a write-one-to-clear alias. A level interrupt is asserted while any flag is set whose enable bit is also set. The counter is driven by an internal divider. The divider is reset on every start command and on every control write, so the first count step lands a known number of cycles after either event.

Top module: `updown_timer`

## Requirements
- R1: After reset every register reads 0, the counter is stopped and `irq_o` is low.
- R2: Byte offsets are fixed as follows: control 0x00, command 0x04, enable 0x0C, flags 0x10, flag-set 0x14, flag-clear 0x18, counter 0x24. A read of command, flag-set, flag-clear or any other offset returns 0. A write to an unmapped offset changes no state. `bus_rdata_o` is 0 unless a read is being strobed.
- R3: Control bits [1:0] select the direction: 0 counts up, 1 counts down. Codes 2 and 3 hold the counter while it is running.
- R4: A command write with bit 0 set starts the counter. A command write with bit 1 set and bit 0 clear stops it. When both bits are set, the start takes effect. A stopped counter does not change.
- R5: Control bits [31:24] give an exponent N; values above 10 act as 10. While running, the counter steps once every 2^N cycles, and the first step comes 2^N cycles after the start.
- R6: Writing the control register restarts the divider phase, in the same way a start command does.
- R7: Counting up from 0xFFFFFFFF gives 0 and sets flag bit 0.
- R8: Counting down from 0 gives 0xFFFFFFFF and sets flag bit 1.
- R9: A flag-set write ORs data bits [1:0] into the flags. A flag-clear write clears the flags whose data bit is 1. A direct write to the flag offset is ignored. A wrap event in the same cycle wins over a clear.
- R10: `irq_o` is high exactly when (flags AND enable) is non-zero. It follows register changes one cycle after the write edge.
- R11: A counter write loads the written value. It takes priority over a count step in the same cycle, and no flag is raised by that step.
- R12: Control reads back all 32 written bits. Enable and flags implement bits [1:0] only, and their upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Access strobe for this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the strobe cycle |
| irq_o | output | 1 | Level interrupt |

## Verification
The embedded properties check on every cycle that the counter holds when no step or load occurs. They also check that a wrap lands on the opposite extreme, that a load is taken exactly, and that start and stop commands change the run state on the next edge. Further cycle-level checks cover the divider clearing, the spacing of steps at a non-zero exponent, and the clear-versus-set priority of each flag.

The bench scenarios are needed to show the following:
- the exact cycle of the first step after a start or a control write;
- saturation of large exponents;
- the hold behaviour of the reserved mode codes;
- that accesses to unmapped offsets have no effect;
- the agreement between readback, flags and the interrupt over long random mixes of register traffic.

// File: rtl/updown_timer_pkg.sv
package updown_timer_pkg;

  typedef enum logic [1:0] {
    MODE_UP    = 2'd0,
    MODE_DOWN  = 2'd1,
    MODE_HOLD2 = 2'd2,
    MODE_HOLD3 = 2'd3
  } cnt_mode_e;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_CMD  = 8'h04;
  localparam logic [7:0] OFS_IEN  = 8'h0C;
  localparam logic [7:0] OFS_FLG  = 8'h10;
  localparam logic [7:0] OFS_FSET = 8'h14;
  localparam logic [7:0] OFS_FCLR = 8'h18;
  localparam logic [7:0] OFS_CNT  = 8'h24;

  localparam int unsigned NUM_FLAGS = 2;
  localparam int unsigned FLG_OVF   = 0;
  localparam int unsigned FLG_UNF   = 1;

endpackage

// File: rtl/updown_timer_presc.sv
module updown_timer_presc #(
  parameter int unsigned EXP_W   = 8,
  parameter int unsigned EXP_MAX = 10,
  localparam int unsigned DIV_W  = (EXP_MAX > 0) ? EXP_MAX : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] div_q, mask;
  logic [EXP_W-1:0] exp_sat;

  assign exp_sat = (exp_i > EXP_W'(EXP_MAX)) ? EXP_W'(EXP_MAX) : exp_i;

  for (genvar i = 0; i < DIV_W; i++) begin : g_mask
    assign mask[i] = (exp_sat > EXP_W'(i));
  end

  assign tick_o = run_i && ((div_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    div_q <= '0;
    else if (clr_i) div_q <= '0;
    else if (run_i) div_q <= div_q + DIV_W'(1);
  end

  AST_DIV_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> div_q == '0) else $error("divider not cleared"); // R6

  AST_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o && (exp_sat != '0) && !clr_i |=> !tick_o) else $error("back-to-back ticks"); // R5

endmodule

// File: rtl/updown_timer_counter.sv
module updown_timer_counter
  import updown_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  cnt_mode_e        mode_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic             unf_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step_up, step_dn;

  assign step_up = tick_i && !load_i && (mode_i == MODE_UP);
  assign step_dn = tick_i && !load_i && (mode_i == MODE_DOWN);
  assign ovf_o   = step_up && (cnt_q == '1);
  assign unf_o   = step_dn && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)       cnt_d = load_val_i;
    else if (step_up) cnt_d = cnt_q + CNT_W'(1);
    else if (step_dn) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_WRAP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> cnt_q == '0) else $error("overflow wrap"); // R7

  AST_WRAP_DN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |=> cnt_q == '1) else $error("underflow wrap"); // R8

  AST_LOAD_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i)) else $error("preload lost"); // R11

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !load_i |=> $stable(cnt_q)) else $error("counter moved while idle"); // R4

endmodule

// File: rtl/updown_timer_flags.sv
module updown_timer_flags #(
  parameter int unsigned NFLAG = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NFLAG-1:0] hw_set_i,
  input  logic             set_we_i,
  input  logic             clr_we_i,
  input  logic             ien_we_i,
  input  logic [NFLAG-1:0] wbits_i,
  output logic [NFLAG-1:0] flags_o,
  output logic [NFLAG-1:0] ien_o,
  output logic             irq_o
);

  logic [NFLAG-1:0] flg_q, ien_q;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    logic nxt;
    always_comb begin
      nxt = flg_q[i];
      if (set_we_i && wbits_i[i]) nxt = 1'b1;
      if (clr_we_i && wbits_i[i]) nxt = 1'b0;
      if (hw_set_i[i])            nxt = 1'b1;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flg_q[i] <= 1'b0;
      else         flg_q[i] <= nxt;
    end

    AST_FLAG_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_we_i && wbits_i[i] && !hw_set_i[i] |=> !flg_q[i]) else $error("clear lost"); // R9

    AST_HW_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hw_set_i[i] |=> flg_q[i]) else $error("event flag lost"); // R9
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ien_q <= '0;
    else if (ien_we_i) ien_q <= wbits_i;
  end

  assign flags_o = flg_q;
  assign ien_o   = ien_q;
  assign irq_o   = |(flg_q & ien_q);

endmodule

// File: rtl/updown_timer.sv
module updown_timer
  import updown_timer_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned EXP_MAX = 10,
  localparam int unsigned EXP_W  = 8,
  localparam int unsigned EXP_LSB = DATA_W - EXP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);

  logic wr, rd;
  logic hit_ctrl, hit_cmd, hit_ien, hit_flg, hit_fset, hit_fclr, hit_cnt;
  logic start, stop;
  logic [DATA_W-1:0] ctrl_q, cnt;
  logic run_q, tick, ovf, unf;
  logic [NUM_FLAGS-1:0] flags, ien, hw_set;
  cnt_mode_e mode;

  assign wr = bus_sel_i && bus_we_i;
  assign rd = bus_sel_i && !bus_we_i;

  assign hit_ctrl = (bus_addr_i == ADDR_W'(OFS_CTRL));
  assign hit_cmd  = (bus_addr_i == ADDR_W'(OFS_CMD));
  assign hit_ien  = (bus_addr_i == ADDR_W'(OFS_IEN));
  assign hit_flg  = (bus_addr_i == ADDR_W'(OFS_FLG));
  assign hit_fset = (bus_addr_i == ADDR_W'(OFS_FSET));
  assign hit_fclr = (bus_addr_i == ADDR_W'(OFS_FCLR));
  assign hit_cnt  = (bus_addr_i == ADDR_W'(OFS_CNT));

  // start has priority when both command bits are set
  assign start = wr && hit_cmd && bus_wdata_i[0];
  assign stop  = wr && hit_cmd && bus_wdata_i[1] && !bus_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      run_q  <= 1'b0;
    end else begin
      if (wr && hit_ctrl) ctrl_q <= bus_wdata_i;
      if (start)          run_q  <= 1'b1;
      else if (stop)      run_q  <= 1'b0;
    end
  end

  assign mode = cnt_mode_e'(ctrl_q[1:0]);

  updown_timer_presc #(
    .EXP_W  (EXP_W),
    .EXP_MAX(EXP_MAX)
  ) i_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run_q),
    .clr_i (start || (wr && hit_ctrl)),
    .exp_i (ctrl_q[DATA_W-1:EXP_LSB]),
    .tick_o(tick)
  );

  updown_timer_counter #(
    .CNT_W(DATA_W)
  ) i_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .mode_i    (mode),
    .load_i    (wr && hit_cnt),
    .load_val_i(bus_wdata_i),
    .cnt_o     (cnt),
    .ovf_o     (ovf),
    .unf_o     (unf)
  );

  always_comb begin
    hw_set          = '0;
    hw_set[FLG_OVF] = ovf;
    hw_set[FLG_UNF] = unf;
  end

  updown_timer_flags #(
    .NFLAG(NUM_FLAGS)
  ) i_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hw_set_i(hw_set),
    .set_we_i(wr && hit_fset),
    .clr_we_i(wr && hit_fclr),
    .ien_we_i(wr && hit_ien),
    .wbits_i (bus_wdata_i[NUM_FLAGS-1:0]),
    .flags_o (flags),
    .ien_o   (ien),
    .irq_o   (irq_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (rd) begin
      if (hit_ctrl)     bus_rdata_o = ctrl_q;
      else if (hit_ien) bus_rdata_o = DATA_W'(ien);
      else if (hit_flg) bus_rdata_o = DATA_W'(flags);
      else if (hit_cnt) bus_rdata_o = cnt;
    end
  end

  AST_START_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> run_q) else $error("start ignored"); // R4

  AST_STOP_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop |=> !run_q) else $error("stop ignored"); // R4

  AST_NO_STEP_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !tick) else $error("tick while stopped"); // R4

  AST_CMD_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && (hit_cmd || hit_fset || hit_fclr) |-> bus_rdata_o == '0) else $error("alias read"); // R2

endmodule

// File: tb/test_updown_timer.sv
`timescale 1ns/1ps
module test_updown_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // reference state
  logic [31:0] m_ctrl, m_cnt;
  logic [1:0]  m_ien, m_if;
  logic        m_run;
  int          m_div;

  always #4 clk = ~clk;

  updown_timer i_updown_timer (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h00:   return m_ctrl;
      8'h0C:   return {30'd0, m_ien};
      8'h10:   return {30'd0, m_if};
      8'h24:   return m_cnt;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h00, 8'h0C: return "R12";
      8'h10:        return "R9";
      8'h24:        return "R11";
      default:      return "R2";
    endcase
  endfunction

  function automatic void model_reset();
    m_ctrl = '0; m_cnt = '0; m_ien = '0; m_if = '0; m_run = 1'b0; m_div = 0;
  endfunction

  function automatic void model_step(input bit s, input bit w, input logic [7:0] a,
                                     input logic [31:0] d);
    int n, msk;
    bit wr, tick, start, stop;
    logic [1:0] hw, nif;
    logic [31:0] ncnt;
    n    = (m_ctrl[31:24] > 8'd10) ? 10 : int'(m_ctrl[31:24]);
    msk  = (1 << n) - 1;
    tick = m_run && ((m_div & msk) == msk);
    wr   = s && w;
    hw   = 2'b00;
    ncnt = m_cnt;
    if (wr && a == 8'h24) ncnt = d;
    else if (tick && m_ctrl[1:0] == 2'd0) begin
      if (m_cnt == 32'hFFFF_FFFF) hw[0] = 1'b1;
      ncnt = m_cnt + 32'd1;
    end else if (tick && m_ctrl[1:0] == 2'd1) begin
      if (m_cnt == 32'd0) hw[1] = 1'b1;
      ncnt = m_cnt - 32'd1;
    end
    start = wr && a == 8'h04 && d[0];
    stop  = wr && a == 8'h04 && d[1] && !d[0];
    nif = m_if;
    if (wr && a == 8'h14) nif = nif | d[1:0];
    if (wr && a == 8'h18) nif = nif & ~d[1:0];
    nif = nif | hw;
    if (start || (wr && a == 8'h00)) m_div = 0;
    else if (m_run) m_div = (m_div + 1) % 1024;
    if (start) m_run = 1'b1; else if (stop) m_run = 1'b0;
    if (wr && a == 8'h00) m_ctrl = d;
    if (wr && a == 8'h0C) m_ien = d[1:0];
    m_if  = nif;
    m_cnt = ncnt;
  endfunction

  task automatic step(input bit s, input bit w, input logic [7:0] a,
                      input logic [31:0] d, input string tag);
    @(negedge clk);
    sel = s; we = w; addr = a; wdata = d;
    #1;
    check({31'd0, irq}, {31'd0, |(m_if & m_ien)}, "R10 irq");
    if (s && !w) check(rdata, exp_read(a), tag);
    if (!s) check(rdata, 32'd0, "R2 idle rdata");
    model_step(s, w, a, d);
    @(posedge clk);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    step(1'b1, 1'b1, a, d, "wr");
  endtask
  task automatic rd_reg(input logic [7:0] a, input string tag);
    step(1'b1, 1'b0, a, 32'd0, tag);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h00, 32'd0, "idle");
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] offs [8];
    offs = '{8'h00, 8'h04, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h24, 8'h08};
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    check({31'd0, irq}, 32'd0, "R1 irq");
    rd_reg(8'h00, "R1 ctrl"); rd_reg(8'h0C, "R1 ien"); rd_reg(8'h10, "R1 flags");
    rd_reg(8'h24, "R1 cnt");
    idle(3); rd_reg(8'h24, "R1 stopped");

    // R7: up wrap, counter continues
    wr_reg(8'h00, 32'h0); wr_reg(8'h0C, 32'h1); wr_reg(8'h24, 32'hFFFF_FFFD);
    wr_reg(8'h04, 32'h1);
    idle(2); rd_reg(8'h24, "R7 pre"); rd_reg(8'h10, "R7 flag"); rd_reg(8'h24, "R7 continue");
    wr_reg(8'h18, 32'h3); rd_reg(8'h10, "R9 cleared");

    // R8: down wrap
    wr_reg(8'h00, 32'h1); wr_reg(8'h0C, 32'h2); wr_reg(8'h24, 32'h1);
    idle(2); rd_reg(8'h10, "R8 flag"); rd_reg(8'h24, "R8 cnt");

    // R4: both bits start, then stop holds
    wr_reg(8'h04, 32'h2); wr_reg(8'h04, 32'h3); idle(4); rd_reg(8'h24, "R4 both start");
    wr_reg(8'h04, 32'h2); idle(5); rd_reg(8'h24, "R4 stopped hold");

    // R5: prescale 3, step every 8 cycles
    wr_reg(8'h00, 32'h0300_0000); wr_reg(8'h24, 32'h0); wr_reg(8'h04, 32'h1);
    for (int i = 0; i < 20; i++) rd_reg(8'h24, "R5 div8");
    // R5: exponent saturates at 10
    wr_reg(8'h00, 32'hFF00_0000); wr_reg(8'h24, 32'h10); wr_reg(8'h04, 32'h1);
    idle(1020);
    for (int i = 0; i < 8; i++) rd_reg(8'h24, "R5 saturate");

    // R6: control rewrite restarts phase
    wr_reg(8'h00, 32'h0200_0000); wr_reg(8'h04, 32'h1); idle(2);
    wr_reg(8'h00, 32'h0200_0000);
    for (int i = 0; i < 10; i++) rd_reg(8'h24, "R6 phase");

    // R3: reserved modes hold
    wr_reg(8'h00, 32'h2); idle(4); rd_reg(8'h24, "R3 hold2");
    wr_reg(8'h00, 32'h3); idle(4); rd_reg(8'h24, "R3 hold3");

    // R11: load beats a wrap step in the same cycle
    wr_reg(8'h18, 32'h3); wr_reg(8'h0C, 32'h3);
    wr_reg(8'h00, 32'h0); wr_reg(8'h24, 32'hFFFF_FFFF); wr_reg(8'h24, 32'h5);
    rd_reg(8'h10, "R11 no flag"); rd_reg(8'h24, "R11 loaded");

    // R9/R2: flag aliases, direct flag write, unmapped accesses
    wr_reg(8'h04, 32'h2);
    wr_reg(8'h14, 32'hFFFF_FFFF); rd_reg(8'h10, "R9 set");
    wr_reg(8'h10, 32'h0); rd_reg(8'h10, "R9 direct ignored");
    wr_reg(8'h18, 32'h1); rd_reg(8'h10, "R9 partial clear");
    wr_reg(8'h08, 32'hFFFF_FFFF); wr_reg(8'h40, 32'h1234_5678);
    rd_reg(8'h00, "R2 ctrl intact"); rd_reg(8'h24, "R2 cnt intact");
    rd_reg(8'h04, "R2 cmd reads 0"); rd_reg(8'h14, "R2 set reads 0");
    rd_reg(8'h18, "R2 clr reads 0"); rd_reg(8'h08, "R2 unmapped");
    wr_reg(8'h0C, 32'h0); rd_reg(8'h10, "R10 masked");

    // random mix
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 6000; i++) begin
      int r;
      logic [7:0] a;
      logic [31:0] d;
      r = $urandom_range(0, 99);
      a = (r < 5) ? 8'($urandom) : offs[$urandom_range(0, 7)];
      d = $urandom;
      if (a == 8'h00) d = {6'd0, 2'($urandom_range(0, 3)), 22'd0, 2'($urandom)};
      if (a == 8'h00 && $urandom_range(0, 9) == 0) d[31:24] = 8'($urandom);
      if (a == 8'h24) d = ($urandom_range(0, 1) != 0) ? 32'hFFFF_FFFF - 32'($urandom_range(0, 4))
                                                      : 32'($urandom_range(0, 4));
      if (a == 8'h04) d = 32'($urandom_range(0, 3));
      if (r < 45) step(1'b1, 1'b0, a, 32'd0, tag_of(a));
      else if (r < 75) step(1'b1, 1'b1, a, d, "wr");
      else step(1'b0, 1'b0, 8'h00, 32'd0, "idle");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule